// File: doc/BRIEF.md
# Ethernet transmit frame assembler

This block gathers one outgoing Ethernet frame from 32-bit words that software writes through a register port, holds it in a byte buffer, and streams it out one byte at a time once it is ready. The first word written into an empty buffer carries the payload length in its low half. The remaining bytes of the frame follow it. The payload length excludes the 14-byte Ethernet header, and the block never generates a CRC.

A frame leaves on its own when two conditions hold together: a programmable fill threshold is met, and the buffer holds enough bytes for the declared frame. Software can also force a frame out with a request write. On the way out, a short frame can be padded with zeros to the Ethernet minimum. When the last byte is taken, the buffer empties and an empty pulse is raised. A length that cannot fit raises an error pulse. Both pulses are meant to feed an interrupt status register outside the block, and acknowledging the error there also clears the buffer.

Top module: `eth_tx_assembler`

## Requirements
- R1: After reset, `ob_valid`, `err_set` and `empty_set` are low and the threshold setting is all ones (63 for 6 bits). That value disables automatic sending, so a complete frame stays held until a request arrives.
- R2: A data write into an empty buffer whose low 16 bits exceed 2032 is discarded. `err_set` pulses high for exactly one cycle after the write, and the buffer stays empty, so the next word is again taken as a length. A length of exactly 2032 is accepted without error.
- R3: Each accepted data write stores four bytes, bits 7:0 first and bits 31:24 last. The frame sent is payload length + 14 bytes, read in order starting at buffer byte 2, so the length half-word is skipped.
- R4: A frame is complete when the stored byte count is at least length + 16, plus 4 more when `crc_auto` is 0, with this total capped at 2048.
- R5: With threshold value t below all ones, the threshold is reached when the stored byte count is at least 32·t + 4. The automatic check runs in the cycle after each accepted data write. It starts sending only if the threshold is reached and the frame is complete.
- R6: A request write with `txreq_go` = 1 starts sending the buffered frame whether or not it is complete; bytes beyond the stored count come from whatever the buffer last held. A request write with `txreq_go` = 0, or any request while the buffer is empty, has no effect.
- R7: With `pad_en` = 1 and length + 14 below 60, the frame is extended to exactly 60 bytes, and every added byte is 0x00. With `pad_en` = 0, no bytes are added.
- R8: In the cycle after the last byte is accepted, `empty_set` is high for one cycle, `ob_valid` is low, and the buffer is empty.
- R9: An `err_clr` pulse empties the buffer. The partly written frame is dropped, and the next word is taken as a new length.
- R10: Data writes made while a frame is streaming out are ignored. They neither change the bytes being sent nor remain in the buffer afterwards.
- R11: A data write that would take the stored count beyond 2048 bytes is ignored and does not wrap. The longest frame sent is 2046 bytes.
- R12: While `ob_valid` is high and `ob_ready` is low, `ob_data` and `ob_last` hold their values. `ob_last` is high only on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_we | input | 1 | Data word write strobe |
| data_wdata | input | 32 | Data word; in an empty buffer the low 16 bits are the payload length |
| txreq_we | input | 1 | Transmit request register write strobe |
| txreq_go | input | 1 | Bit 0 of the request write; 1 forces sending |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 6 | Threshold value; all ones disables automatic sending |
| err_clr | input | 1 | Error acknowledge pulse; empties the buffer |
| crc_auto | input | 1 | 1 when CRC is appended downstream (no CRC bytes expected in the buffer) |
| pad_en | input | 1 | Enables zero padding of short frames to 60 bytes |
| ob_ready | input | 1 | Downstream accepts the byte this cycle |
| ob_valid | output | 1 | Output byte valid |
| ob_data | output | 8 | Output byte |
| ob_last | output | 1 | Final byte of the frame |
| err_set | output | 1 | One-cycle pulse: length word rejected |
| empty_set | output | 1 | One-cycle pulse: frame sent, buffer empty |

## Verification
The hardest point to reach from the ports is the buffer's upper edge. A 2032-byte payload with `crc_auto` low needs 2052 bytes, more than the buffer holds, so the completeness cap at 2048 and the ignored overflow write only show after more than 500 word writes. The bench writes such frames in full, twice. Once it keeps writing past the end with automatic sending disabled, forces the frame out and compares all 2046 bytes. Once it lets the threshold fire and confirms that sending starts on exactly the 512th word. The other subtle case is a write made during streaming. The bench forces out a frame shorter than its declared length, holds `ob_ready` low, and writes words that would land inside the bytes still to be sent; it then checks those bytes and the frame that follows.

// File: rtl/eth_txa_pkg.sv
// Package: shared constants for the transmit frame assembler.
// Assumes byte-addressed buffer; all counts are in bytes.
package eth_txa_pkg;
    localparam int ETH_HDR_BYTES = 14;  // destination, source, type
    localparam int LEN_HDR_BYTES = 2;   // length half-word ahead of the frame
    localparam int CRC_BYTES     = 4;   // trailing CRC held in buffer when not automatic
    localparam int MIN_FRAME     = 60;  // minimum frame without CRC
    localparam int WORD_BYTES    = 4;   // bytes per register data write
endpackage

// File: rtl/eth_txa_store.sv
// Module: frame byte buffer with fill count and length capture.
// Accepts 32-bit writes little-endian, parses the first word of a frame as
// the payload length, rejects oversize lengths and overflowing writes.
// Assumes the fill count only moves in whole words and that the reader
// (streamer) raises busy for the whole time it reads the buffer.
module eth_txa_store
    import eth_txa_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int FILL_W    = 12,
    parameter int ADDR_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              flush,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [FILL_W-1:0] fill,
    output logic [15:0]       plen,
    output logic              wr_ok,
    output logic              len_err,
    output logic [7:0]        rd_byte
);
    localparam int MAX_PAYLOAD = BUF_BYTES - ETH_HDR_BYTES - LEN_HDR_BYTES;

    logic [7:0]        mem [BUF_BYTES];
    logic [FILL_W:0]   fill_plus;
    logic              room;
    logic              head;
    logic              bad_len;
    logic              accept;
    logic [ADDR_W-1:0] wr_base;

    // Decode whether the incoming word fits and whether it is a valid head.
    always_comb begin
        fill_plus = {1'b0, fill} + (FILL_W+1)'(WORD_BYTES);
        room      = fill_plus <= (FILL_W+1)'(BUF_BYTES);
        head      = (fill == '0);
        bad_len   = head && ({16'b0, wdata[15:0]} > 32'(MAX_PAYLOAD));
        accept    = wr_en && !busy && !bad_len && room;
        wr_base   = fill[ADDR_W-1:0];
    end

    // Fill count, length capture and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill    <= '0;
            plen    <= '0;
            wr_ok   <= 1'b0;
            len_err <= 1'b0;
        end else begin
            wr_ok   <= accept;
            len_err <= wr_en && !busy && bad_len;
            if (done || flush) begin
                fill <= '0;
            end else if (accept) begin
                fill <= fill_plus[FILL_W-1:0];
            end
            if (accept && head) begin
                plen <= wdata[15:0];
            end
        end
    end

    // Byte storage, least significant byte at the lowest address.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                mem[wr_base + ADDR_W'(k)] <= wdata[8*k +: 8];
            end
        end
    end

    // Asynchronous read port for the streamer.
    assign rd_byte = mem[rd_addr];

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(BUF_BYTES));

    // R2
    len_err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (fill == '0));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !flush) |=> $stable(fill));
endmodule

// File: rtl/eth_txa_launch.sv
// Module: send decision and frame sizing.
// Holds the threshold register, evaluates threshold and completeness after
// each accepted write, honours forced requests, and sizes the outgoing frame
// (payload + header, optional pad to the minimum, capped to the buffer).
// Assumes the fill count and length come from the buffer and are stable
// while the streamer is busy.
module eth_txa_launch
    import eth_txa_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int FILL_W    = 12,
    parameter int THR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic              crc_auto,
    input  logic              pad_en,
    input  logic              wr_ok,
    input  logic              req,
    input  logic              busy,
    input  logic [FILL_W-1:0] fill,
    input  logic [15:0]       plen,
    output logic              start,
    output logic [FILL_W-1:0] send_len,
    output logic [FILL_W-1:0] data_len
);
    localparam int SEND_CAP = BUF_BYTES - LEN_HDR_BYTES;

    logic [THR_W-1:0] thr_q;
    logic [31:0]      fill32, need32, lvl32, dl32, sl32;
    logic             thr_on, auto_go;

    // Threshold register, disabled value at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '1;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

    // Completeness, threshold level and outgoing lengths.
    always_comb begin
        fill32 = 32'(fill);
        need32 = 32'(plen) + 32'(ETH_HDR_BYTES + LEN_HDR_BYTES)
               + (crc_auto ? 32'd0 : 32'(CRC_BYTES));
        if (need32 > 32'(BUF_BYTES)) need32 = 32'(BUF_BYTES);
        lvl32  = (32'(thr_q) << 5) + 32'd4;
        thr_on = (thr_q != '1);
        dl32   = 32'(plen) + 32'(ETH_HDR_BYTES);
        if (dl32 > 32'(SEND_CAP)) dl32 = 32'(SEND_CAP);
        sl32   = (pad_en && dl32 < 32'(MIN_FRAME)) ? 32'(MIN_FRAME) : dl32;
        auto_go = wr_ok && thr_on && (fill32 >= lvl32) && (fill32 >= need32);
        start    = !busy && (fill != '0) && (auto_go || req);
        send_len = FILL_W'(sl32);
        data_len = FILL_W'(dl32);
    end
endmodule

// File: rtl/eth_txa_stream.sv
// Module: byte streamer with valid/ready handshake.
// Latches the frame sizes on start, reads the buffer from byte 2 onward,
// substitutes zero bytes past the data length, flags the final byte.
// Assumes the buffer content does not change while busy.
module eth_txa_stream #(
    parameter int FILL_W = 12,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FILL_W-1:0] send_len,
    input  logic [FILL_W-1:0] data_len,
    input  logic [7:0]        rd_byte,
    input  logic              ob_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ob_valid,
    output logic [7:0]        ob_data,
    output logic              ob_last,
    output logic              done,
    output logic              busy
);
    logic              active;
    logic [FILL_W-1:0] idx, slen_q, dlen_q;
    logic [FILL_W-1:0] idx_rd;

    // Output decode for the current byte position.
    always_comb begin
        idx_rd   = idx + FILL_W'(2);
        rd_addr  = idx_rd[ADDR_W-1:0];
        ob_valid = active;
        ob_data  = (idx < dlen_q) ? rd_byte : 8'h00;
        ob_last  = active && (idx == slen_q - FILL_W'(1));
        done     = active && ob_ready && ob_last;
        busy     = active;
    end

    // Frame position and latched sizes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            slen_q <= '0;
            dlen_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            slen_q <= send_len;
            dlen_q <= data_len;
        end else if (active && ob_ready) begin
            if (ob_last) begin
                active <= 1'b0;
            end
            idx <= idx + FILL_W'(1);
        end
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_data) && $stable(ob_last)));

    // R8
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ob_valid);
endmodule

// File: rtl/eth_tx_assembler.sv
// Module: transmit frame assembler top.
// Ties buffer, send decision and streamer together and registers the
// empty pulse. Assumes register writes arrive one per cycle at most and
// that status pulses are collected by an external interrupt register.
module eth_tx_assembler #(
    parameter int BUF_BYTES = 2048,
    parameter int THR_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic [31:0]      data_wdata,
    input  logic             txreq_we,
    input  logic             txreq_go,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             err_clr,
    input  logic             crc_auto,
    input  logic             pad_en,
    input  logic             ob_ready,
    output logic             ob_valid,
    output logic [7:0]       ob_data,
    output logic             ob_last,
    output logic             err_set,
    output logic             empty_set
);
    localparam int FILL_W = $clog2(BUF_BYTES + 1);
    localparam int ADDR_W = $clog2(BUF_BYTES);

    logic [FILL_W-1:0] fill, send_len, data_len;
    logic [15:0]       plen;
    logic              wr_ok, start, done, busy;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_byte;

    eth_txa_store #(.BUF_BYTES(BUF_BYTES), .FILL_W(FILL_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(data_we), .wdata(data_wdata),
        .busy(busy), .done(done), .flush(err_clr), .rd_addr(rd_addr),
        .fill(fill), .plen(plen), .wr_ok(wr_ok), .len_err(err_set),
        .rd_byte(rd_byte)
    );

    eth_txa_launch #(.BUF_BYTES(BUF_BYTES), .FILL_W(FILL_W), .THR_W(THR_W)) u_launch (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .crc_auto(crc_auto), .pad_en(pad_en), .wr_ok(wr_ok),
        .req(txreq_we && txreq_go), .busy(busy), .fill(fill), .plen(plen),
        .start(start), .send_len(send_len), .data_len(data_len)
    );

    eth_txa_stream #(.FILL_W(FILL_W), .ADDR_W(ADDR_W)) u_stream (
        .clk(clk), .rst_n(rst_n), .start(start), .send_len(send_len),
        .data_len(data_len), .rd_byte(rd_byte), .ob_ready(ob_ready),
        .rd_addr(rd_addr), .ob_valid(ob_valid), .ob_data(ob_data),
        .ob_last(ob_last), .done(done), .busy(busy)
    );

    // Empty pulse one cycle after the final byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_set <= 1'b0;
        end else begin
            empty_set <= done;
        end
    end

    // R8
    empty_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_set |-> ((fill == '0) && !ob_valid));
endmodule

// File: tb/sim_eth_tx_assembler.sv
// Bench: sweeps frame lengths, thresholds and options; models the buffer
// bytes and computes expected send points and frame contents arithmetically.
module sim_eth_tx_assembler;
    localparam int BUF = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_we = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        txreq_we = 1'b0;
    logic        txreq_go = 1'b0;
    logic        thr_we = 1'b0;
    logic [5:0]  thr_wdata = '0;
    logic        err_clr = 1'b0;
    logic        crc_auto = 1'b1;
    logic        pad_en = 1'b0;
    logic        ob_ready = 1'b0;
    logic        ob_valid;
    logic [7:0]  ob_data;
    logic        ob_last;
    logic        err_set;
    logic        empty_set;

    int nchk = 0;
    int nerr = 0;
    int rp = 0;
    int cur_thr = 63;
    logic [31:0] seed = 32'h1234_5678;
    logic [7:0]  bm [BUF];
    int bfill = 0;

    eth_tx_assembler u0 (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
        .txreq_we(txreq_we), .txreq_go(txreq_go), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .err_clr(err_clr), .crc_auto(crc_auto),
        .pad_en(pad_en), .ob_ready(ob_ready), .ob_valid(ob_valid),
        .ob_data(ob_data), .ob_last(ob_last), .err_set(err_set),
        .empty_set(empty_set)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Drive one data word; mirror it in the model when modelled.
    task automatic put(input logic [31:0] v, input bit model_on);
        @(negedge clk);
        data_we = 1'b1;
        data_wdata = v;
        @(negedge clk);
        data_we = 1'b0;
        if (model_on) begin
            if (!(bfill == 0 && v[15:0] > 16'd2032) && bfill + 4 <= BUF) begin
                for (int k = 0; k < 4; k++) bm[bfill + k] = v[8*k +: 8];
                bfill += 4;
            end
        end
    endtask

    task automatic set_thr(input int t);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = 6'(t);
        @(negedge clk);
        thr_we = 1'b0;
        cur_thr = t;
    endtask

    task automatic req(input bit go);
        @(negedge clk);
        txreq_we = 1'b1;
        txreq_go = go;
        @(negedge clk);
        txreq_we = 1'b0;
        txreq_go = 1'b0;
    endtask

    // Take one frame with a varying ready pattern and compare it to the model.
    task automatic get_frame(input int exp_len, input int dlen, input int cmp_lim, input string tag);
        int n = 0;
        int bad = 0;
        int sbad = 0;
        int guard = 0;
        bit fin = 1'b0;
        bit pst = 1'b0;
        logic [7:0] pd = '0;
        logic [7:0] e;
        while (!fin && guard < 8000) begin
            @(negedge clk);
            guard++;
            if (pst && (!ob_valid || ob_data !== pd)) sbad++;
            ob_ready = ((rp % 3) != 1);
            rp++;
            pst = ob_valid && !ob_ready;
            pd = ob_data;
            if (ob_valid && ob_ready) begin
                e = (n < dlen) ? bm[2 + n] : 8'h00;
                if (n < cmp_lim && ob_data !== e) bad++;
                if (ob_last) fin = 1'b1;
                n++;
            end
        end
        @(negedge clk);
        ob_ready = 1'b0;
        // R3 byte order and offset; R7 zero pad bytes
        check(bad == 0, {tag, " R3 frame bytes mismatched"}, bad, 0);
        check(n == exp_len, {tag, " frame length"}, n, exp_len);
        // R12 hold under stall
        check(sbad == 0, "R12 data held while stalled", sbad, 0);
        // R8 empty pulse and idle
        check(empty_set === 1'b1 && ob_valid === 1'b0, "R8 empty pulse after last", int'(empty_set), 1);
        @(negedge clk);
        check(empty_set === 1'b0, "R8 empty pulse one cycle", int'(empty_set), 0);
        bfill = 0;
    endtask

    // Write a frame word by word and compare each automatic send decision.
    task automatic run_frame(input int len, input string tag);
        int need;
        int lvl;
        int bad = 0;
        int words = 0;
        bit sent = 1'b0;
        bit expd;
        logic [31:0] h;
        h = nxt();
        put({h[31:16], 16'(len)}, 1'b1);
        need = len + 16 + (crc_auto ? 0 : 4);
        if (need > BUF) need = BUF;
        lvl = 32 * cur_thr + 4;
        while (!sent && words < 520) begin
            @(negedge clk);
            sent = ob_valid;
            expd = (cur_thr != 63) && (bfill >= need) && (bfill >= lvl);
            if (sent !== expd) bad++;
            if (!sent) begin
                put(nxt(), 1'b1);
                words++;
            end
        end
        // R4 completeness, R5 threshold
        check(bad == 0, {tag, " send point"}, bad, 0);
        get_frame((pad_en && len + 14 < 60) ? 60 : len + 14, len + 14, BUF, tag);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int bad;
        for (int i = 0; i < BUF; i++) bm[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ob_valid === 1'b0 && err_set === 1'b0 && empty_set === 1'b0,
              "R1 outputs after reset", int'(ob_valid), 0);

        // R1 default threshold holds a complete frame
        bad = 0;
        put({16'hBEEF, 16'd4}, 1'b1);
        for (int w = 0; w < 5; w++) begin
            put(nxt(), 1'b1);
            @(negedge clk);
            if (ob_valid !== 1'b0) bad++;
        end
        check(bad == 0, "R1 no auto send at default threshold", bad, 0);
        req(1'b1);
        check(ob_valid === 1'b1, "R6 request starts send", int'(ob_valid), 1);
        get_frame(18, 18, BUF, "R6");

        // R6 request with go=0 ignored, go=1 forces incomplete frame
        put({16'h0102, 16'd30}, 1'b1);
        put(nxt(), 1'b1);
        put(nxt(), 1'b1);
        req(1'b0);
        @(negedge clk);
        check(ob_valid === 1'b0, "R6 go=0 no effect", int'(ob_valid), 0);
        req(1'b1);
        check(ob_valid === 1'b1, "R6 forced send", int'(ob_valid), 1);
        get_frame(44, 44, 10, "R6");
        req(1'b1);
        @(negedge clk);
        check(ob_valid === 1'b0, "R6 request on empty buffer ignored", int'(ob_valid), 0);

        // R4 completeness sweep, both CRC modes, threshold 0
        set_thr(0);
        for (int c = 0; c < 2; c++) begin
            crc_auto = c[0];
            for (int l = 0; l <= 40; l++) run_frame(l, "R4");
        end

        // R5 threshold sweep
        crc_auto = 1'b1;
        for (int t = 1; t <= 3; t++) begin
            set_thr(t);
            run_frame(0, "R5");
            run_frame(7, "R5");
            run_frame(33, "R5");
            run_frame(50, "R5");
        end

        // R7 padding sweep
        set_thr(0);
        pad_en = 1'b1;
        for (int l = 0; l <= 50; l++) run_frame(l, "R7");
        pad_en = 1'b0;

        // R2 oversize lengths rejected
        put({16'h1234, 16'd2033}, 1'b1);
        check(err_set === 1'b1, "R2 error pulse on 2033", int'(err_set), 1);
        @(negedge clk);
        check(err_set === 1'b0, "R2 error pulse one cycle", int'(err_set), 0);
        put(32'h0000_FFFF, 1'b1);
        check(err_set === 1'b1, "R2 error pulse on 65535", int'(err_set), 1);
        run_frame(3, "R2");

        // R9 error acknowledge empties buffer
        set_thr(63);
        put({16'h5555, 16'd10}, 1'b1);
        put(nxt(), 1'b1);
        put(nxt(), 1'b1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        bfill = 0;
        set_thr(0);
        run_frame(2, "R9");

        // R10 writes during streaming ignored
        set_thr(63);
        put({16'hAAAA, 16'd60}, 1'b1);
        for (int w = 0; w < 4; w++) put(nxt(), 1'b1);
        req(1'b1);
        check(ob_valid === 1'b1, "R10 forced send begins", int'(ob_valid), 1);
        for (int w = 0; w < 3; w++) put(32'hDEAD_BEEF, 1'b0);
        get_frame(74, 74, 30, "R10");
        set_thr(0);
        run_frame(1, "R10");

        // R11 overflow writes ignored, longest frame
        set_thr(63);
        crc_auto = 1'b0;
        put({16'h7777, 16'd2032}, 1'b1);
        check(err_set === 1'b0, "R2 length 2032 accepted", int'(err_set), 0);
        for (int w = 0; w < 515; w++) put(nxt(), 1'b1);
        req(1'b1);
        get_frame(2046, 2046, 2046, "R11");

        // R4 completeness capped at buffer size
        set_thr(0);
        run_frame(2032, "R4");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule